// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. It is a shift register whose feedback taps are set by a divisor polynomial parameter. The same hardware produces a frame check sequence for an outgoing frame and validates an incoming one. The arithmetic is plain modulo-2 long division. The register starts from all zeros, and there is no bit reflection and no final inversion.

To generate, the user pulses `clear` and then presents the message on `dataIn`, most significant bit first, with `dataValid` high on each bit. The user then presents as many zero bits as the polynomial's degree. The remainder output then holds the check sequence. Its top bit is the first one to append after the message.

To check, the user clears the register, shifts in the whole received frame (message followed by check sequence), and holds `checkMode` high. `crcErr` then reports any non-zero remainder.

Top module: `crc_serial_unit`

## Requirements
- R1: An active-low `rst_n`, or a `clear` sampled high at a rising edge, sets every remainder bit to 0. `clear` wins over `dataValid` in the same cycle.
- R2: On an edge where `clear` and `dataValid` are both low, the remainder keeps its value whatever `dataIn` is.
- R3: On an edge with `dataValid` high and `clear` low, each stage i>0 takes the old stage i-1, XORed with the old top bit when coefficient i of the divisor is 1. Stage 0 takes `dataIn` XOR the old top bit. Example: with divisor 110101, shifting 1,0,0,0,0 gives 10000, and one further 0 gives 10101.
- R4: After a clear, shifting a k-bit message MSB first and then DEG zero bits leaves the remainder of (message·x^DEG) divided by the divisor. Example: divisor 110101 with message 1010001101 gives 01110.
- R5: `remainder[DEG-1]` is the first check bit sent after the message, and `remainder[0]` is the last.
- R6: A frame formed from a message followed by its check sequence in the R5 order leaves a zero remainder. With `checkMode` high, `crcErr` is then 0.
- R7: With `checkMode` high, `crcErr` is 1 exactly when the remainder is non-zero. With `checkMode` low, `crcErr` is 0.
- R8: Flipping any single bit of a valid frame gives a non-zero remainder. Example: divisor 11001 with message 00111011001 gives check sequence 0100.
- R9: DEG and POLY are parameters, and the default is x^16+x^12+x^5+1. The x^16+x^15+x^2+1 divisor behaves per R4 and R6 as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the remainder register |
| dataIn | input | 1 | Serial bit to divide in |
| dataValid | input | 1 | Shift strobe for `dataIn` |
| checkMode | input | 1 | 1 = check a received frame, 0 = generate |
| remainder | output | DEG | Current register contents; MSB is the first check bit |
| crcErr | output | 1 | Non-zero remainder while checking |

## Verification
The bench sweeps every 10-bit message through the degree-5 divisor and every 11-bit message through the degree-4 divisor. For each message it compares the generated remainder with long division computed in the bench, then feeds the frame back in check mode. A tap placed on the wrong stage, or a missing stage-0 XOR, gives wrong check sequences for most messages. Appending the check bits LSB first makes valid frames fail the check. All single-bit flips of the 15-bit degree-4 frame are applied, and a dropped feedback term would let some of them through. The bench also asserts `clear` together with `dataValid`, drives `dataIn` freely while `dataValid` is low, and shows a non-zero remainder in generate mode, which catches a clear that loses priority, a register that shifts without the strobe, and an error flag that ignores the mode.

// File: rtl/crc_pkg.sv
package crc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;    // zero the register
    logic shift;  // divide one bit in
  } crcStrobe_t;

endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
(
  input  logic       clear,
  input  logic       dataValid,
  input  logic       checkMode,
  input  logic       remNonZero,
  output crcStrobe_t strb,
  output logic       crcErr
);

  always_comb begin
    strb.clr   = clear;
    strb.shift = dataValid & ~clear;  // clear takes priority (R1)
  end

  // Error flag only meaningful while checking (R7)
  assign crcErr = checkMode & remNonZero;

endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_pkg::*;
#(
  parameter int         DEG  = 16,
  parameter logic [DEG:0] POLY = 17'h11021
) (
  input  logic           clk,
  input  logic           rst_n,
  input  crcStrobe_t     strb,
  input  logic           dataIn,
  output logic [DEG-1:0] regQ,
  output logic           remNonZero
);

  localparam int TOP = DEG - 1;

  logic           fb;
  logic [DEG-1:0] nxt;

  assign fb = regQ[TOP];

  // Feedback network: one stage per remainder bit, taps from POLY
  for (genvar i = 0; i < DEG; i++) begin : g_stage
    if (i == 0) begin : g_in
      assign nxt[i] = dataIn ^ fb;
    end else if (POLY[i]) begin : g_tap
      assign nxt[i] = regQ[i-1] ^ fb;
    end else begin : g_pass
      assign nxt[i] = regQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          regQ <= '0;
    else if (strb.clr)   regQ <= '0;
    else if (strb.shift) regQ <= nxt;
  end

  assign remNonZero = |regQ;

  // R3: no feedback when top bit is clear -> plain shift
  a_r3_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.shift && !regQ[TOP]) |=> (regQ == {$past(regQ[TOP-1:0]), $past(dataIn)}));

  // R3: feedback always inverts the input bit at stage 0
  a_r3_stage0_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.shift && regQ[TOP]) |=> (regQ[0] != $past(dataIn)));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_pkg::*;
#(
  parameter int           DEG  = 16,
  parameter logic [DEG:0] POLY = 17'h11021
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           dataIn,
  input  logic           dataValid,
  input  logic           checkMode,
  output logic [DEG-1:0] remainder,
  output logic           crcErr
);

  crcStrobe_t strb;
  logic       remNonZero;

  crc_ctrl u_ctrl (
    .clear      (clear),
    .dataValid  (dataValid),
    .checkMode  (checkMode),
    .remNonZero (remNonZero),
    .strb       (strb),
    .crcErr     (crcErr)
  );

  crc_datapath #(.DEG(DEG), .POLY(POLY)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .dataIn     (dataIn),
    .regQ       (remainder),
    .remNonZero (remNonZero)
  );

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (remainder == '0));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !dataValid) |=> $stable(remainder));

  a_r7_flag_in_check: assert property (@(posedge clk) disable iff (!rst_n)
    (checkMode && remainder != '0) |-> crcErr);

  a_r7_quiet_in_gen: assert property (@(posedge clk) disable iff (!rst_n)
    !checkMode |-> !crcErr);

endmodule

// File: tb/tb_crc_serial_unit.sv
module tb_crc_serial_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic clr [4];
  logic din [4];
  logic vld [4];
  logic mode[4];
  logic err [4];
  logic [15:0] remW[4];

  logic [4:0]  r0;
  logic [3:0]  r1;
  logic [15:0] r2, r3;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  crc_serial_unit #(.DEG(5), .POLY(6'b110101)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clr[0]), .dataIn(din[0]), .dataValid(vld[0]),
    .checkMode(mode[0]), .remainder(r0), .crcErr(err[0]));
  crc_serial_unit #(.DEG(4), .POLY(5'b11001)) dut4 (
    .clk(clk), .rst_n(rst_n), .clear(clr[1]), .dataIn(din[1]), .dataValid(vld[1]),
    .checkMode(mode[1]), .remainder(r1), .crcErr(err[1]));
  crc_serial_unit dutA (
    .clk(clk), .rst_n(rst_n), .clear(clr[2]), .dataIn(din[2]), .dataValid(vld[2]),
    .checkMode(mode[2]), .remainder(r2), .crcErr(err[2]));
  crc_serial_unit #(.DEG(16), .POLY(17'h18005)) dutB (
    .clk(clk), .rst_n(rst_n), .clear(clr[3]), .dataIn(din[3]), .dataValid(vld[3]),
    .checkMode(mode[3]), .remainder(r3), .crcErr(err[3]));

  assign remW[0] = {11'b0, r0};
  assign remW[1] = {12'b0, r1};
  assign remW[2] = r2;
  assign remW[3] = r3;

  function automatic int degOf(input int w);
    case (w)
      0: degOf = 5;
      1: degOf = 4;
      default: degOf = 16;
    endcase
  endfunction

  function automatic logic [63:0] polyOf(input int w);
    case (w)
      0: polyOf = 64'h35;
      1: polyOf = 64'h19;
      2: polyOf = 64'h11021;
      default: polyOf = 64'h18005;
    endcase
  endfunction

  // Modulo-2 long division of msg * x^deg by the divisor
  function automatic logic [15:0] refRem(input int w, input logic [31:0] msg, input int k);
    logic [63:0] v;
    int d;
    d = degOf(w);
    v = 64'(msg) << d;
    for (int b = k + d - 1; b >= d; b--)
      if (v[b]) v = v ^ (polyOf(w) << (b - d));
    refRem = 16'(v & ((64'd1 << d) - 1));
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // clear, then shift len bits of bits MSB first
  task automatic runFrame(input int w, input logic [63:0] bits, input int len, input logic chk);
    @(negedge clk);
    mode[w] = chk; clr[w] = 1'b1; vld[w] = 1'b0;
    @(negedge clk);
    clr[w] = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      din[w] = bits[i]; vld[w] = 1'b1;
      @(negedge clk);
    end
    vld[w] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] fcs, held;
    logic [63:0] frame;
    for (int w = 0; w < 4; w++) begin
      clr[w] = 0; din[w] = 0; vld[w] = 0; mode[w] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int w = 0; w < 4; w++) begin
      check("R1 reset rem", 32'(remW[w]), 0);
      check("R7 reset flag", 32'(err[w]), 0);
    end
    rst_n = 1'b1;

    // R3: explicit step sequence on degree 5 divisor
    runFrame(0, 64'b10000, 5, 1'b0);
    check("R3 shift 10000", 32'(r0), 32'b10000);
    @(negedge clk); din[0] = 1'b0; vld[0] = 1'b1;
    @(negedge clk); vld[0] = 1'b0;
    check("R3 feedback", 32'(r0), 32'b10101);
    // R7: non-zero remainder in generate mode leaves flag low
    check("R7 gen mode quiet", 32'(err[0]), 0);

    // R2: no strobe, toggle data
    held = remW[0];
    for (int i = 0; i < 6; i++) begin
      din[0] = i[0];
      @(negedge clk);
    end
    check("R2 hold", 32'(r0), 32'(held));

    // R1: clear beats valid
    clr[0] = 1'b1; vld[0] = 1'b1; din[0] = 1'b1;
    @(negedge clk);
    clr[0] = 1'b0; vld[0] = 1'b0;
    check("R1 clear priority", 32'(r0), 0);

    // R4: known vector
    runFrame(0, 64'b1010001101 << 5, 15, 1'b0);
    check("R4 vector 01110", 32'(r0), 32'b01110);
    // R6: known frame
    runFrame(0, 64'b101000110101110, 15, 1'b1);
    check("R6 frame zero", 32'(r0), 0);
    check("R6 flag low", 32'(err[0]), 0);

    // R8: known degree-4 vector and all single flips
    runFrame(1, 64'b00111011001 << 4, 15, 1'b0);
    check("R8 vector 0100", 32'(r1), 32'b0100);
    for (int f = 0; f < 15; f++) begin
      runFrame(1, (64'b001110110010100) ^ (64'd1 << f), 15, 1'b1);
      check("R8 flip flag", 32'(err[1]), 1);
      check("R7 flip nonzero", 32'(r1 != 0), 1);
    end

    // R4/R5/R6 sweep, degree 5, all 10-bit messages
    for (int m = 0; m < 1024; m++) begin
      fcs = refRem(0, 32'(m), 10);
      runFrame(0, 64'(m) << 5, 15, 1'b0);
      check("R4 sweep deg5", 32'(r0), 32'(fcs));
      frame = (64'(m) << 5) | 64'(fcs);  // R5 order: rem MSB first
      runFrame(0, frame, 15, 1'b1);
      check("R5 R6 check deg5", 32'({err[0], r0}), 0);
    end

    // sweep degree 4, all 11-bit messages
    for (int m = 0; m < 2048; m++) begin
      fcs = refRem(1, 32'(m), 11);
      runFrame(1, 64'(m) << 4, 15, 1'b0);
      check("R4 sweep deg4", 32'(r1), 32'(fcs));
      runFrame(1, (64'(m) << 4) | 64'(fcs), 15, 1'b1);
      check("R6 check deg4", 32'({err[1], r1}), 0);
    end

    // R9: 16-bit divisors
    for (int w = 2; w < 4; w++) begin
      for (int m = 0; m < 48; m++) begin
        logic [15:0] msg;
        msg = 16'(m * 16'h9e37 + 16'h1234);
        fcs = refRem(w, 32'(msg), 16);
        runFrame(w, 64'(msg) << 16, 32, 1'b0);
        check("R9 gen 16", 32'(remW[w]), 32'(fcs));
        runFrame(w, (64'(msg) << 16) | 64'(fcs), 32, 1'b1);
        check("R9 check 16", 32'({err[w], remW[w]}), 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule